// File: doc/BRIEF.md
# Serial Dual-Converter Command Interface

This block is the digital front end of a two-channel, 10-bit, voltage-output converter. A host talks to it over a three-wire serial link made of an active-low select/load line, a shift clock and a data line. Every command frame carries a 4-bit operation code, a 10-bit sample value and two padding bits. The block decodes the frame when the select line returns high. It then acts on two double-buffered channels and on a shared sleep/wake state. Each channel has a staging register and an output register.

The serial lines are asynchronous to the block clock. They pass through synchronizers, and the block detects their edges in the `clk` domain. The outputs go to the analog section. They are the two output-register codes, one output-enable flag per channel (low while asleep, which stands for high-impedance outputs) and a sleep status flag. Staging writes can be queued while the part sleeps. A later update or wake command then brings them to the outputs.

Top module: `dual_dac_cmd`

## Requirements
- R1: A frame is the run of shift-clock rising edges while `ser_cs_n` is low. Bits enter most significant first. After 16 bits, bits 15..12 hold the opcode, bits 11..2 hold the sample and bits 1..0 are ignored. Shift-clock edges while `ser_cs_n` is high have no effect.
- R2: The decoded command executes on the rising edge of `ser_cs_n`. Its result is visible on the outputs no later than 8 `clk` cycles after that edge is applied.
- R3: Opcode 4'b0000 changes no register and leaves the sleep state as it is.
- R4: Opcode 4'b0001 writes the sample into staging register A, and 4'b0010 into staging register B. Neither changes an output register or the sleep state, including while asleep.
- R5: Opcode 4'b1000 copies both staging registers into both output registers in the same cycle and wakes the part.
- R6: Opcode 4'b1001 writes staging A and then loads both output registers from the staging registers (new A, existing B) and wakes the part. Opcode 4'b1010 does the same for B.
- R7: Opcode 4'b1101 wakes the part with all registers unchanged. Opcode 4'b1110 puts it to sleep with all registers unchanged and drives both output enables low.
- R8: Opcode 4'b1111 writes the sample into both staging and both output registers and wakes the part.
- R9: Opcodes 4'b0011 to 4'b0111, 4'b1011 and 4'b1100 change no register and leave the sleep state as it is.
- R10: If a frame has more than 16 shift edges, only the last 16 bits shifted in are decoded.
- R11: A frame with fewer than 16 shift edges executes nothing.
- R12: After reset, all four registers are zero, `sleeping` is 1 and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs_n | input | 1 | Serial select/load, active low; its rising edge executes the frame |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| dac_a_code | output | 10 | Output register of channel A |
| dac_b_code | output | 10 | Output register of channel B |
| out_en_a | output | 1 | Channel A output enable, low while asleep |
| out_en_b | output | 1 | Channel B output enable, low while asleep |
| sleeping | output | 1 | High while in the sleep state |

## Verification
The assertions guard four properties on every cycle:
- No register or sleep-state change happens outside an execute strobe.
- Reserved and load-only opcodes leave the output registers and the power state alone.
- The sleep and wake opcodes land in the right state.
- The bit counter stays bounded, and the shift register holds still while the select line is high.

Other behaviour needs whole serial frames, so only the bench scenarios can show it:
- the bit order and field positions;
- that short frames are dropped;
- that long frames keep only their last 16 bits;
- that a staging value written during sleep appears only after a later update.

// File: rtl/dual_dac_cmd_pkg.sv
package dual_dac_cmd_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE     = 4'b0000,
    OP_STAGE_A  = 4'b0001,
    OP_STAGE_B  = 4'b0010,
    OP_PUSH     = 4'b1000,
    OP_STAGE_PA = 4'b1001,
    OP_STAGE_PB = 4'b1010,
    OP_WAKE     = 4'b1101,
    OP_SLEEP    = 4'b1110,
    OP_BOTH     = 4'b1111
  } op_e;

  function automatic logic op_writes_a(input logic [OP_W-1:0] op);
    return (op == OP_STAGE_A) || (op == OP_STAGE_PA) || (op == OP_BOTH);
  endfunction

  function automatic logic op_writes_b(input logic [OP_W-1:0] op);
    return (op == OP_STAGE_B) || (op == OP_STAGE_PB) || (op == OP_BOTH);
  endfunction

  function automatic logic op_pushes(input logic [OP_W-1:0] op);
    return (op == OP_PUSH) || (op == OP_STAGE_PA) || (op == OP_STAGE_PB) ||
           (op == OP_BOTH);
  endfunction

  function automatic logic op_wakes(input logic [OP_W-1:0] op);
    return op_pushes(op) || (op == OP_WAKE);
  endfunction

  function automatic logic op_sleeps(input logic [OP_W-1:0] op);
    return op == OP_SLEEP;
  endfunction

  function automatic logic op_inert(input logic [OP_W-1:0] op);
    return !(op_writes_a(op) || op_writes_b(op) || op_wakes(op) || op_sleeps(op));
  endfunction

endpackage

// File: rtl/dual_dac_cmd_sync.sv
module dual_dac_cmd_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain_q <= async_i[b];
      else chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/dual_dac_cmd_shift.sv
module dual_dac_cmd_shift #(
  parameter int WORD_W = 16,
  parameter int HEAD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              din_s,
  output logic              exec_stb,
  output logic [HEAD_W-1:0] head_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              cs_prev_q, sck_prev_q;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bit_cnt_q;

  logic cs_rise, cs_fall, sck_rise, shift_en, frame_full;

  assign cs_rise    = cs_n_s && !cs_prev_q;
  assign cs_fall    = !cs_n_s && cs_prev_q;
  assign sck_rise   = sck_s && !sck_prev_q;
  assign shift_en   = sck_rise && !cs_n_s;
  assign frame_full = (bit_cnt_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      cs_prev_q  <= cs_n_s;
      sck_prev_q <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      bit_cnt_q <= '0;
    end else if (cs_fall) begin
      bit_cnt_q <= '0;
    end else if (shift_en) begin
      shreg_q <= {shreg_q[WORD_W-2:0], din_s};
      if (!frame_full) bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  assign exec_stb = cs_rise && frame_full;
  assign head_o   = shreg_q[WORD_W-1 -: HEAD_W];

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= FULL);

  // R1
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && !cs_fall) |=> $stable(shreg_q));

endmodule

// File: rtl/dual_dac_cmd_regs.sv
module dual_dac_cmd_regs
  import dual_dac_cmd_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_stb,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_a_o,
  output logic [DATA_W-1:0] out_b_o,
  output logic              asleep_o
);

  logic [DATA_W-1:0] stg_a_q, stg_b_q, out_a_q, out_b_q;
  logic [DATA_W-1:0] stg_a_d, stg_b_d;
  logic              asleep_q;
  logic              wr_a, wr_b, push, wake, sleep;

  assign wr_a  = exec_stb && op_writes_a(op_i);
  assign wr_b  = exec_stb && op_writes_b(op_i);
  assign push  = exec_stb && op_pushes(op_i);
  assign wake  = exec_stb && op_wakes(op_i);
  assign sleep = exec_stb && op_sleeps(op_i);

  always_comb begin
    stg_a_d = wr_a ? data_i : stg_a_q;
    stg_b_d = wr_b ? data_i : stg_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a_q  <= '0;
      stg_b_q  <= '0;
      out_a_q  <= '0;
      out_b_q  <= '0;
      asleep_q <= 1'b1;
    end else begin
      stg_a_q <= stg_a_d;
      stg_b_q <= stg_b_d;
      if (push) begin
        out_a_q <= stg_a_d;
        out_b_q <= stg_b_d;
      end
      if (sleep)     asleep_q <= 1'b1;
      else if (wake) asleep_q <= 1'b0;
    end
  end

  assign out_a_o  = out_a_q;
  assign out_b_o  = out_b_q;
  assign asleep_o = asleep_q;

  // R2
  no_stray_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb |=> $stable({stg_a_q, stg_b_q, out_a_q, out_b_q, asleep_q}));

  // R9
  reserved_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && op_inert(op_i)) |=>
      $stable({stg_a_q, stg_b_q, out_a_q, out_b_q, asleep_q}));

  // R4
  stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && (op_i == OP_STAGE_A || op_i == OP_STAGE_B)) |=>
      $stable({out_a_q, out_b_q, asleep_q}));

  // R7
  sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && op_i == OP_SLEEP) |=> (asleep_q && $stable({out_a_q, out_b_q})));

  // R5
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && (op_i == OP_PUSH || op_i == OP_WAKE || op_i == OP_BOTH)) |=> !asleep_q);

endmodule

// File: rtl/dual_dac_cmd.sv
module dual_dac_cmd
  import dual_dac_cmd_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [DATA_W-1:0] dac_a_code,
  output logic [DATA_W-1:0] dac_b_code,
  output logic              out_en_a,
  output logic              out_en_b,
  output logic              sleeping
);

  localparam int HEAD_W = OP_W + DATA_W;
  localparam int WORD_W = HEAD_W + PAD_W;

  logic [2:0]        sync_v;
  logic              exec_stb, asleep;
  logic [HEAD_W-1:0] head;

  dual_dac_cmd_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ser_cs_n, ser_clk, ser_din}),
    .sync_o (sync_v)
  );

  dual_dac_cmd_shift #(
    .WORD_W(WORD_W),
    .HEAD_W(HEAD_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (sync_v[2]),
    .sck_s   (sync_v[1]),
    .din_s   (sync_v[0]),
    .exec_stb(exec_stb),
    .head_o  (head)
  );

  dual_dac_cmd_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_stb(exec_stb),
    .op_i    (head[HEAD_W-1 -: OP_W]),
    .data_i  (head[DATA_W-1:0]),
    .out_a_o (dac_a_code),
    .out_b_o (dac_b_code),
    .asleep_o(asleep)
  );

  assign sleeping = asleep;
  assign out_en_a = !asleep;
  assign out_en_b = !asleep;

  // R12
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> (!out_en_a && !out_en_b));

endmodule

// File: tb/sim_dual_dac_cmd.sv
module sim_dual_dac_cmd;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, din = 1'b0;
  logic [9:0] qa, qb;
  logic       ena, enb, slp;
  int         checks = 0, fails = 0;
  logic [9:0] ea = '0, eb = '0;
  logic       es = 1'b1;

  always #2 clk = ~clk;

  dual_dac_cmd u0 (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sck), .ser_din(din),
    .dac_a_code(qa), .dac_b_code(qb), .out_en_a(ena), .out_en_b(enb),
    .sleeping(slp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_state(input string req);
    @(negedge clk);
    chk({req, " dac_a"}, 32'(qa), 32'(ea));
    chk({req, " dac_b"}, 32'(qb), 32'(eb));
    chk({req, " sleeping"}, 32'(slp), 32'(es));
    chk({req, " out_en"}, {30'b0, ena, enb}, {30'b0, !es, !es});
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    @(negedge clk); cs_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0; din = bits[i];
      wait_clk(4);
      sck = 1'b1;
      wait_clk(4);
    end
    sck = 1'b0;
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic send_cmd(input logic [3:0] op, input logic [9:0] d, input logic [1:0] pad);
    send_bits({16'b0, op, d, pad}, 16);
  endtask

  task automatic t_reset;
    expect_state("R12 reset");
  endtask

  task automatic t_stage_then_push;
    send_cmd(4'b0001, 10'h155, 2'b00);
    expect_state("R4 stage A asleep");
    send_cmd(4'b0010, 10'h2AA, 2'b11);
    expect_state("R4 stage B asleep");
    send_cmd(4'b1000, 10'h000, 2'b00);
    ea = 10'h155; eb = 10'h2AA; es = 1'b0;
    expect_state("R5 push both and wake");
  endtask

  task automatic t_nop;
    send_cmd(4'b0000, 10'h3FF, 2'b11);
    expect_state("R3 nop");
    send_cmd(4'b1000, 10'h000, 2'b00);
    expect_state("R3 staging unchanged after nop");
  endtask

  task automatic t_sleep_wake;
    send_cmd(4'b1110, 10'h3FF, 2'b00);
    es = 1'b1;
    expect_state("R7 sleep");
    send_cmd(4'b0001, 10'h0AB, 2'b00);
    expect_state("R4 stage A keeps sleep");
    send_cmd(4'b1101, 10'h3FF, 2'b00);
    es = 1'b0;
    expect_state("R7 wake keeps registers");
    send_cmd(4'b1000, 10'h000, 2'b00);
    ea = 10'h0AB;
    expect_state("R5 push shows staged A");
  endtask

  task automatic t_stage_push;
    send_cmd(4'b1110, 10'h000, 2'b00);
    es = 1'b1;
    send_cmd(4'b1001, 10'h3FF, 2'b00);
    ea = 10'h3FF; es = 1'b0;
    expect_state("R6 stage-push A wakes");
    send_cmd(4'b1010, 10'h001, 2'b10);
    eb = 10'h001;
    expect_state("R6 stage-push B");
  endtask

  task automatic t_reserved;
    logic [3:0] codes [7] = '{4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'hC};
    foreach (codes[k]) begin
      send_cmd(codes[k], 10'h3C3, 2'b01);
      expect_state($sformatf("R9 reserved %0h", codes[k]));
    end
    send_cmd(4'b1000, 10'h000, 2'b00);
    expect_state("R9 staging untouched by reserved");
    send_cmd(4'b1110, 10'h000, 2'b00);
    es = 1'b1;
    send_cmd(4'hC, 10'h3C3, 2'b00);
    expect_state("R9 reserved keeps sleep");
  endtask

  task automatic t_both;
    send_cmd(4'b1111, 10'h200, 2'b00);
    ea = 10'h200; eb = 10'h200; es = 1'b0;
    expect_state("R8 write both");
    send_cmd(4'b1110, 10'h000, 2'b00);
    send_cmd(4'b1000, 10'h000, 2'b00);
    expect_state("R8 staging holds shared value");
  endtask

  task automatic t_long_frame;
    send_bits({12'b0, 4'b1110, 4'b1001, 10'h123, 2'b11}, 20);
    ea = 10'h123;
    expect_state("R10 last 16 bits decoded");
  endtask

  task automatic t_short_frame;
    logic [15:0] w;
    w = {4'b1111, 10'h0F0, 2'b00};
    send_bits({17'b0, w[15:1]}, 15);
    expect_state("R11 15-bit frame ignored");
    send_bits(32'b0, 0);
    expect_state("R11 empty frame ignored");
  endtask

  task automatic t_idle_clock;
    din = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sck = 1'b1; wait_clk(4);
      sck = 1'b0; wait_clk(4);
    end
    wait_clk(8);
    expect_state("R1 shift clock with select high ignored");
    send_cmd(4'b1010, 10'h2F0, 2'b11);
    eb = 10'h2F0;
    expect_state("R1 msb-first frame after idle clocks");
    send_cmd(4'b1001, 10'h00F, 2'b00);
    ea = 10'h00F;
    expect_state("R2 execute at select rise");
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_stage_then_push();
    t_nop();
    t_sleep_wake();
    t_stage_push();
    t_reserved();
    t_both();
    t_long_frame();
    t_short_frame();
    t_idle_clock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule